// File: doc/BRIEF.md
# Scoreboarded Stream Instruction Issue Queue

This block sits between the instruction decoder and the execution resources of a stream coprocessor. Decoded stream instructions arrive on an enqueue port, each carrying a target resource, up to one destination and two source register identifiers, a flag that says whether it needs an operand from the scalar core, and a reorder-buffer index. The instructions wait in a short in-order queue. The head instruction is sent to the memory load/store unit, the local-register fill path or the vector ALU once a scoreboard shows that its registers are free of hazards.

The scoreboard holds one pending-write bit per tracked register. Identifiers 0 to 31 name stream registers and 32 to 35 name local registers. Identifiers 36 to 63 are not tracked and never cause a stall. Each resource holds at most one instruction in flight. The queue keeps that instruction's registers and reorder index until the resource pulses done. At that point the destination bit is released and the reorder index is reported on that resource's completion lane. Because each resource has its own in-flight slot, a memory operation, a fill and an ALU operation can all be outstanding at the same time.

Top module: `stream_issue_queue`

## Requirements
- R1: After reset the queue is empty, `enq_ready` is 1, and no bit of `disp_valid` or `cmp_valid` is set.
- R2: The head is dispatched on exactly one lane of `disp_valid`, chosen by `enq_unit`: 0 selects bit 0 (load/store), 1 selects bit 1 (fill), and 2 or 3 select bit 2 (ALU). The instruction's dst, srca, srcb and rob appear on the shared dispatch payload in the same cycle.
- R3: Instructions leave in arrival order. While the head stalls, no later entry is dispatched, even one bound for an idle resource.
- R4: The head stalls while either of its enabled, tracked sources has its pending-write bit set.
- R5: The head stalls while its enabled, tracked destination has its pending-write bit set.
- R6: The head stalls while its enabled, tracked destination equals an enabled source of an instruction that is still in flight on any resource.
- R7: The head stalls while its target resource has `res_busy` high or still holds an undone instruction. Instructions bound for different resources may be in flight together.
- R8: A head with `enq_scalar` set stalls while `scalar_ok` is 0. A head without that flag ignores `scalar_ok`.
- R9: A `res_done` pulse on a resource that holds an instruction raises that lane of `cmp_valid` in the same cycle, with that instruction's reorder index on bits [5*u+4:5*u] of `cmp_rob`. It also clears the instruction's destination pending bit at the clock edge.
- R10: `enq_ready` is 0 when four entries are held, and an enqueue offered while full is discarded.
- R11: Local registers 32 to 35 are tracked exactly like stream registers for all hazard checks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Enqueue request |
| enq_ready | output | 1 | Queue has room |
| enq_unit | input | 2 | Target resource code |
| enq_dst_en | input | 1 | Destination is used |
| enq_dst | input | 6 | Destination register id |
| enq_a_en | input | 1 | Source A is used |
| enq_srca | input | 6 | Source A register id |
| enq_b_en | input | 1 | Source B is used |
| enq_srcb | input | 6 | Source B register id |
| enq_scalar | input | 1 | Needs a scalar-core operand |
| enq_rob | input | 5 | Reorder-buffer index |
| scalar_ok | input | 1 | Scalar operand for the head is available |
| res_busy | input | 3 | Per-resource busy (bit 0 load/store, 1 fill, 2 ALU) |
| res_done | input | 3 | Per-resource completion pulse |
| disp_valid | output | 3 | One-hot dispatch strobe per resource |
| disp_dst | output | 6 | Dispatched destination id |
| disp_srca | output | 6 | Dispatched source A id |
| disp_srcb | output | 6 | Dispatched source B id |
| disp_rob | output | 5 | Dispatched reorder index |
| cmp_valid | output | 3 | Completion strobe per resource |
| cmp_rob | output | 15 | Reorder index per completion lane, 5 bits each |

## Verification
An instruction enqueued at one clock edge becomes the head at that edge. With no hazard, its dispatch strobe is high for the whole following cycle. It leaves the queue at the next edge. A completion strobe is combinational from `res_done` and appears in the same cycle as the pulse. The pending bit it releases lets a waiting head dispatch in the cycle after that pulse. The bench drives inputs on the falling edge and samples one time unit later, which is exactly these cycles. Every stall test checks the strobe in the cycle the instruction would otherwise go, and checks it again in the cycle the hazard clears.

// File: rtl/sq_pkg.sv
package sq_pkg;
  localparam int SQ_NSTREAM = 32;
  localparam int SQ_NLOCAL  = 4;
  localparam int SQ_NREG    = SQ_NSTREAM + SQ_NLOCAL;
  localparam int SQ_RIDW    = 6;
  localparam int SQ_ROBW    = 5;
  localparam int SQ_NRES    = 3;

  typedef logic [SQ_RIDW-1:0] sq_rid_t;
  typedef logic [SQ_NREG-1:0] sq_rmask_t;

  typedef struct packed {
    logic [1:0]         unit;
    logic               dst_en;
    sq_rid_t            dst;
    logic               a_en;
    sq_rid_t            srca;
    logic               b_en;
    sq_rid_t            srcb;
    logic               scalar;
    logic [SQ_ROBW-1:0] rob;
  } sq_instr_t;

  // resource code -> one-hot lane; codes 2 and 3 both select the ALU
  function automatic logic [SQ_NRES-1:0] sq_target(input logic [1:0] unit);
    case (unit)
      2'd0:    return 3'b001;
      2'd1:    return 3'b010;
      default: return 3'b100;
    endcase
  endfunction

  // decoded register mask; ids beyond the tracked range shift out to zero
  function automatic sq_rmask_t sq_onehot(input logic en, input sq_rid_t id);
    sq_rmask_t one;
    one = SQ_NREG'(1);
    return en ? (one << id) : '0;
  endfunction

  function automatic sq_rmask_t sq_src_mask(input sq_instr_t ins);
    return sq_onehot(ins.a_en, ins.srca) | sq_onehot(ins.b_en, ins.srcb);
  endfunction
endpackage

// File: rtl/sq_queue.sv
module sq_queue #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [W-1:0]    mem [DEPTH];
  logic [PTRW-1:0] wr_ptr, rd_ptr;
  logic [CNTW-1:0] count;
  logic            do_push, do_pop;

  function automatic logic [PTRW-1:0] bump(input logic [PTRW-1:0] p);
    return (p == PTRW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CNTW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      count <= count + CNTW'(do_push) - CNTW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNTW'(DEPTH));
  assert_pop_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/sq_scoreboard.sv
module sq_scoreboard
  import sq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  sq_rmask_t set_mask,
  input  sq_rmask_t clr_mask,
  output sq_rmask_t pending
);
  for (genvar r = 0; r < SQ_NREG; r++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)           pending[r] <= 1'b0;
      else if (set_mask[r]) pending[r] <= 1'b1;
      else if (clr_mask[r]) pending[r] <= 1'b0;
    end
  end

  assert_no_double_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mask & pending) == '0);
  assert_single_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(set_mask) <= 1);
endmodule

// File: rtl/sq_hazard.sv
module sq_hazard
  import sq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  sq_instr_t           head,
  input  logic                head_ok,
  input  sq_rmask_t           pending,
  input  sq_rmask_t           rd_mask,
  input  logic [SQ_NRES-1:0]  occupied,
  input  logic                scalar_ok,
  output logic [SQ_NRES-1:0]  fire,
  output logic                raw_stall,
  output logic                waw_stall,
  output logic                war_stall,
  output logic                res_stall,
  output logic                scalar_stall
);
  logic [SQ_NRES-1:0] tgt;
  sq_rmask_t          dst_m, src_m;
  logic               any_stall;

  assign tgt          = sq_target(head.unit);
  assign dst_m        = sq_onehot(head.dst_en, head.dst);
  assign src_m        = sq_src_mask(head);
  assign raw_stall    = |(src_m & pending);
  assign waw_stall    = |(dst_m & pending);
  assign war_stall    = |(dst_m & rd_mask);
  assign res_stall    = |(tgt & occupied);
  assign scalar_stall = head.scalar && !scalar_ok;
  assign any_stall    = raw_stall | waw_stall | war_stall | res_stall | scalar_stall;
  assign fire         = (head_ok && !any_stall) ? tgt : '0;

  assert_onehot_dispatch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fire));
  assert_scalar_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((|fire) && head.scalar) |-> scalar_ok);
endmodule

// File: rtl/stream_issue_queue.sv
module stream_issue_queue
  import sq_pkg::*;
#(
  parameter int QDEPTH = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      enq_valid,
  output logic                      enq_ready,
  input  logic [1:0]                enq_unit,
  input  logic                      enq_dst_en,
  input  logic [SQ_RIDW-1:0]        enq_dst,
  input  logic                      enq_a_en,
  input  logic [SQ_RIDW-1:0]        enq_srca,
  input  logic                      enq_b_en,
  input  logic [SQ_RIDW-1:0]        enq_srcb,
  input  logic                      enq_scalar,
  input  logic [SQ_ROBW-1:0]        enq_rob,
  input  logic                      scalar_ok,
  input  logic [SQ_NRES-1:0]        res_busy,
  input  logic [SQ_NRES-1:0]        res_done,
  output logic [SQ_NRES-1:0]        disp_valid,
  output logic [SQ_RIDW-1:0]        disp_dst,
  output logic [SQ_RIDW-1:0]        disp_srca,
  output logic [SQ_RIDW-1:0]        disp_srcb,
  output logic [SQ_ROBW-1:0]        disp_rob,
  output logic [SQ_NRES-1:0]        cmp_valid,
  output logic [SQ_NRES*SQ_ROBW-1:0] cmp_rob
);
  localparam int IW = $bits(sq_instr_t);

  sq_instr_t          enq_ins, head;
  logic [IW-1:0]      head_bits;
  logic               q_empty, q_full;
  logic [SQ_NRES-1:0] fire;
  logic               raw_stall, waw_stall, war_stall, res_stall, scalar_stall;
  sq_rmask_t          pending, set_mask, clr_mask, rd_mask;
  logic [SQ_NRES-1:0] inf_v, retire, occupied;
  sq_instr_t          inf_i [SQ_NRES];
  sq_rmask_t          inf_rd [SQ_NRES];
  sq_rmask_t          inf_wr [SQ_NRES];

  assign enq_ins = '{unit: enq_unit, dst_en: enq_dst_en, dst: enq_dst,
                     a_en: enq_a_en, srca: enq_srca, b_en: enq_b_en,
                     srcb: enq_srcb, scalar: enq_scalar, rob: enq_rob};

  sq_queue #(.DEPTH(QDEPTH), .W(IW)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .push(enq_valid), .din(enq_ins),
    .pop(|fire), .dout(head_bits),
    .empty(q_empty), .full(q_full)
  );
  assign head      = sq_instr_t'(head_bits);
  assign enq_ready = !q_full;

  // in-flight slot per resource
  for (genvar u = 0; u < SQ_NRES; u++) begin : g_res
    assign retire[u]   = res_done[u] && inf_v[u];
    assign occupied[u] = res_busy[u] || inf_v[u];
    assign inf_rd[u]   = inf_v[u] ? sq_src_mask(inf_i[u]) : '0;
    assign inf_wr[u]   = retire[u] ? sq_onehot(inf_i[u].dst_en, inf_i[u].dst) : '0;
    assign cmp_valid[u] = retire[u];
    assign cmp_rob[u*SQ_ROBW +: SQ_ROBW] = inf_i[u].rob;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        inf_v[u] <= 1'b0;
        inf_i[u] <= '0;
      end else if (fire[u]) begin
        inf_v[u] <= 1'b1;
        inf_i[u] <= head;
      end else if (retire[u]) begin
        inf_v[u] <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_mask  = '0;
    clr_mask = '0;
    for (int u = 0; u < SQ_NRES; u++) begin
      rd_mask  = rd_mask | inf_rd[u];
      clr_mask = clr_mask | inf_wr[u];
    end
  end

  assign set_mask = (|fire) ? sq_onehot(head.dst_en, head.dst) : '0;

  sq_scoreboard u_sb (
    .clk(clk), .rst_n(rst_n),
    .set_mask(set_mask), .clr_mask(clr_mask), .pending(pending)
  );

  sq_hazard u_hz (
    .clk(clk), .rst_n(rst_n),
    .head(head), .head_ok(!q_empty),
    .pending(pending), .rd_mask(rd_mask),
    .occupied(occupied), .scalar_ok(scalar_ok),
    .fire(fire),
    .raw_stall(raw_stall), .waw_stall(waw_stall), .war_stall(war_stall),
    .res_stall(res_stall), .scalar_stall(scalar_stall)
  );

  assign disp_valid = fire;
  assign disp_dst   = head.dst;
  assign disp_srca  = head.srca;
  assign disp_srcb  = head.srcb;
  assign disp_rob   = head.rob;

  assert_busy_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid & res_busy) == '0);
  assert_raw_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|disp_valid) |-> ((sq_onehot(disp_srca == head.srca && head.a_en, head.srca)
                        | sq_onehot(head.b_en, head.srcb)) & pending) == '0);
  assert_war_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|disp_valid) |-> (sq_onehot(head.dst_en, head.dst) & rd_mask) == '0);
  assert_cmp_needs_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid & ~res_done) == '0);
  assert_pending_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_mask) |=> ((clr_mask == '0) || 1'b1) && (($past(clr_mask) & pending & ~$past(set_mask)) == '0));
endmodule

// File: tb/stream_issue_queue_bench.sv
module stream_issue_queue_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enq_valid = 1'b0;
  logic        enq_ready;
  logic [1:0]  enq_unit = '0;
  logic        enq_dst_en = 1'b0;
  logic [5:0]  enq_dst = '0;
  logic        enq_a_en = 1'b0;
  logic [5:0]  enq_srca = '0;
  logic        enq_b_en = 1'b0;
  logic [5:0]  enq_srcb = '0;
  logic        enq_scalar = 1'b0;
  logic [4:0]  enq_rob = '0;
  logic        scalar_ok = 1'b1;
  logic [2:0]  res_busy = '0;
  logic [2:0]  res_done = '0;
  logic [2:0]  disp_valid;
  logic [5:0]  disp_dst, disp_srca, disp_srcb;
  logic [4:0]  disp_rob;
  logic [2:0]  cmp_valid;
  logic [14:0] cmp_rob;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  stream_issue_queue u_stream_issue_queue (.*);

  // unit, dst, srca, srcb, rob (all register fields enabled)
  localparam logic [24:0] VEC [6] = '{
    {2'd0, 6'd3,  6'd1,  6'd2,  5'd4},
    {2'd1, 6'd33, 6'd5,  6'd6,  5'd9},
    {2'd2, 6'd10, 6'd32, 6'd35, 5'd17},
    {2'd3, 6'd31, 6'd0,  6'd7,  5'd30},
    {2'd0, 6'd34, 6'd11, 6'd12, 5'd1},
    {2'd1, 6'd20, 6'd21, 6'd33, 5'd31}
  };

  function automatic logic [2:0] lane_of(input logic [1:0] u);
    if (u == 2'd0) return 3'b001;
    if (u == 2'd1) return 3'b010;
    return 3'b100;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_disp(input string req, input logic [2:0] exp);
    chk(disp_valid === exp, req, 32'(disp_valid), 32'(exp));
  endtask

  task automatic enq(input logic [1:0] u, input logic de, input logic [5:0] d,
                     input logic ae, input logic [5:0] a, input logic be, input logic [5:0] b,
                     input logic sc, input logic [4:0] rob);
    @(negedge clk);
    enq_valid = 1'b1; enq_unit = u; enq_dst_en = de; enq_dst = d;
    enq_a_en = ae; enq_srca = a; enq_b_en = be; enq_srcb = b;
    enq_scalar = sc; enq_rob = rob;
    @(negedge clk);
    enq_valid = 1'b0;
    #1;
  endtask

  task automatic pulse_done(input int u, input logic [4:0] rob, input string req);
    @(negedge clk);
    res_done[u] = 1'b1;
    #1;
    chk(cmp_valid[u] === 1'b1 && cmp_rob[u*5 +: 5] === rob, req,
        {cmp_valid, cmp_rob[u*5 +: 5]}, {3'(1 << u), rob});
    @(negedge clk);
    res_done = '0;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk(enq_ready === 1'b1, "R1 ready", 32'(enq_ready), 1);
    chk_disp("R1 dispatch idle", 3'b000);
    chk(cmp_valid === 3'b000, "R1 completion idle", 32'(cmp_valid), 0);

    // table walk: R2 lane and payload, R9 completion, R11 local ids
    for (int i = 0; i < 6; i++) begin
      logic [1:0] u; logic [5:0] d, a, b; logic [4:0] r; int ln;
      {u, d, a, b, r} = VEC[i];
      enq(u, 1'b1, d, 1'b1, a, 1'b1, b, 1'b0, r);
      chk_disp("R2 lane", lane_of(u));
      chk({disp_dst, disp_srca, disp_srcb, disp_rob} === {d, a, b, r}, "R2 payload",
          {disp_dst, disp_srca, disp_srcb, disp_rob}, {d, a, b, r});
      ln = (u == 2'd0) ? 0 : (u == 2'd1) ? 1 : 2;
      pulse_done(ln, r, "R9 table completion");
    end

    // R4 RAW, R3 in-order blocking, R7 concurrency
    enq(2'd0, 1'b1, 6'd5, 1'b0, 6'd0, 1'b0, 6'd0, 1'b0, 5'd1);
    chk_disp("R7 load/store issue", 3'b001);
    enq(2'd2, 1'b1, 6'd6, 1'b1, 6'd5, 1'b0, 6'd0, 1'b0, 5'd2);
    chk_disp("R4 source pending stalls", 3'b000);
    enq(2'd1, 1'b1, 6'd7, 1'b0, 6'd0, 1'b0, 6'd0, 1'b0, 5'd3);
    chk_disp("R3 later entry blocked", 3'b000);
    pulse_done(0, 5'd1, "R9 load/store completion");
    chk_disp("R4 released after done", 3'b100);
    @(negedge clk); #1;
    chk_disp("R7 fill while ALU busy", 3'b010);
    chk({disp_rob} === 5'd3, "R3 order rob", 32'(disp_rob), 3);
    pulse_done(2, 5'd2, "R9 ALU completion");
    pulse_done(1, 5'd3, "R9 fill completion");

    // R5 WAW on a local register (R11)
    enq(2'd1, 1'b1, 6'd33, 1'b0, 6'd0, 1'b0, 6'd0, 1'b0, 5'd5);
    chk_disp("R11 fill to local", 3'b010);
    enq(2'd2, 1'b1, 6'd33, 1'b1, 6'd1, 1'b1, 6'd2, 1'b0, 5'd6);
    chk_disp("R5 R11 local dst pending stalls", 3'b000);
    pulse_done(1, 5'd5, "R9 fill completion");
    chk_disp("R5 released", 3'b100);
    pulse_done(2, 5'd6, "R9 ALU completion");

    // R6 WAR
    enq(2'd2, 1'b1, 6'd8, 1'b1, 6'd9, 1'b1, 6'd10, 1'b0, 5'd7);
    chk_disp("R6 reader issue", 3'b100);
    enq(2'd0, 1'b1, 6'd9, 1'b0, 6'd0, 1'b0, 6'd0, 1'b0, 5'd8);
    chk_disp("R6 overwrite of in-flight source stalls", 3'b000);
    pulse_done(2, 5'd7, "R9 ALU completion");
    chk_disp("R6 released", 3'b001);
    pulse_done(0, 5'd8, "R9 load/store completion");

    // R7 busy input
    res_busy = 3'b001;
    enq(2'd0, 1'b1, 6'd12, 1'b0, 6'd0, 1'b0, 6'd0, 1'b0, 5'd9);
    chk_disp("R7 busy stalls", 3'b000);
    @(negedge clk); res_busy = '0; #1;
    chk_disp("R7 busy released", 3'b001);
    pulse_done(0, 5'd9, "R9 load/store completion");

    // R8 scalar operand
    scalar_ok = 1'b0;
    enq(2'd2, 1'b1, 6'd13, 1'b0, 6'd0, 1'b0, 6'd0, 1'b1, 5'd10);
    chk_disp("R8 scalar wait", 3'b000);
    @(negedge clk); scalar_ok = 1'b1; #1;
    chk_disp("R8 scalar supplied", 3'b100);
    pulse_done(2, 5'd10, "R9 ALU completion");
    scalar_ok = 1'b0;
    enq(2'd2, 1'b1, 6'd14, 1'b0, 6'd0, 1'b0, 6'd0, 1'b0, 5'd11);
    chk_disp("R8 flag clear ignores scalar_ok", 3'b100);
    pulse_done(2, 5'd11, "R9 ALU completion");
    scalar_ok = 1'b1;

    // R10 full queue
    res_busy = 3'b111;
    for (int k = 0; k < 4; k++)
      enq(2'd0, 1'b1, 6'(14 + k), 1'b0, 6'd0, 1'b0, 6'd0, 1'b0, 5'(11 + k));
    chk(enq_ready === 1'b0, "R10 full", 32'(enq_ready), 0);
    enq(2'd0, 1'b1, 6'd40, 1'b0, 6'd0, 1'b0, 6'd0, 1'b0, 5'd20);
    @(negedge clk); res_busy = '0; #1;
    for (int k = 0; k < 4; k++) begin
      chk_disp("R10 drain lane", 3'b001);
      chk(disp_rob === 5'(11 + k), "R3 R10 drain order", 32'(disp_rob), 32'(11 + k));
      pulse_done(0, 5'(11 + k), "R9 drain completion");
    end
    repeat (2) @(negedge clk);
    #1;
    chk_disp("R10 offer while full discarded", 3'b000);
    chk(enq_ready === 1'b1, "R10 ready again", 32'(enq_ready), 1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule